// File: doc/BRIEF.md
# Integer Add/Subtract Flag Unit

This block performs the integer add and subtract family on 8, 16 or 32 bit operands. The family covers plain add, add with carry-in, subtract, subtract with borrow-in, increment, decrement, compare and two's-complement negation. A one-cycle `start_i` pulse captures the opcode, the operand size and two operands. On the next clock edge the block registers the sized result and a six-bit flag word, and raises `done_o` for one cycle.

The flag word is kept in a register. It is the source of the carry that the carry-chained opcodes consume. A caller can therefore build wide additions and subtractions by issuing an add followed by carry-chained adds on consecutive cycles, with no extra bookkeeping. Increment and decrement leave the stored carry untouched. Compare updates every flag but keeps the previously registered result.

Top module: `addsub_flag_unit`

## Requirements
- R1: After reset, `result_o`, `flags_o` and `done_o` are all zero. A `start_i` sampled high on a rising edge makes `done_o` high in the following cycle, with the new result and flags visible in that same cycle. Without `start_i`, `done_o` is low and the result and flags hold.
- R2: `op_i` encodes the operations as follows: 0 add, 1 add-with-carry, 2 subtract (a-b), 3 subtract-with-borrow, 4 increment a, 5 decrement a, 6 compare (a-b), 7 negate a. `size_i` encodes the operand size: 0 byte, 1 word, 2 or 3 doubleword. Operand bits above the size are ignored. Result bits above the size read zero.
- R3: `flags_o` bit 0 is carry. For add-type operations it is the carry out of the top bit of the size. For subtract, compare and negate it is the borrow into that top bit.
- R4: Add-with-carry adds one more when the stored carry is 1. Subtract-with-borrow subtracts one more when the stored carry is 1. With the stored carry at 0, each behaves like its plain form.
- R5: Increment and decrement keep carry (bit 0) at its previous value and update every other flag.
- R6: Compare sets all flags exactly as subtract would, and leaves `result_o` unchanged.
- R7: Negate returns 0-a in the selected size. Its carry is 1 exactly when the sized a is non-zero.
- R8: Bit 3 (zero) is set exactly when the sized result is all zeros. Bit 4 (sign) is the top bit of the sized result.
- R9: Bit 5 (overflow) is set when the result, read as a signed number of the selected size, differs from the true signed sum or difference.
- R10: Bit 2 (auxiliary) is the carry out of, or borrow into, bit 3 to bit 4. Bit 1 (parity) is set when bits 7..0 of the result hold an even number of ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture operation this cycle |
| op_i | input | 3 | Operation code |
| size_i | input | 2 | Operand size code |
| a_i | input | 32 | Destination/first operand |
| b_i | input | 32 | Source/second operand |
| result_o | output | 32 | Registered sized result, zero-extended |
| flags_o | output | 6 | Registered flags {overflow, sign, zero, aux, parity, carry} |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
Two functions can collide in one cycle: the flag write of one operation and the carry read of a carry-chained operation started on the very next cycle. The bench provokes this by issuing operations back to back, with `start_i` held across consecutive edges. One case is a 32-bit add that carries out, followed immediately by add-with-carry. Another is a subtract that borrows, followed immediately by subtract-with-borrow. Each chained result is judged against a model that uses the carry it predicted for the previous operation. The bench also places a compare directly after a result-writing operation, to confirm that the fresh result survives the compare's flag update.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

    localparam int DATA_W = 32;
    localparam int FLAG_W = 6;
    localparam int IDX_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_INC = 3'd4,
        OP_DEC = 3'd5,
        OP_CMP = 3'd6,
        OP_NEG = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_DWALT = 2'd3
    } size_e;

    typedef struct packed {
        logic ovf;
        logic sign;
        logic zero;
        logic aux;
        logic par;
        logic carry;
    } flags_t;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        flags_t            flags;
        logic              done;
    } unit_state_t;

    function automatic logic [DATA_W-1:0] size_mask(size_e sz);
        case (sz)
            SZ_BYTE: size_mask = DATA_W'(32'h0000_00FF);
            SZ_WORD: size_mask = DATA_W'(32'h0000_FFFF);
            default: size_mask = '1;
        endcase
    endfunction

    function automatic logic [IDX_W-1:0] top_bit(size_e sz);
        case (sz)
            SZ_BYTE: top_bit = IDX_W'(7);
            SZ_WORD: top_bit = IDX_W'(15);
            default: top_bit = IDX_W'(DATA_W - 1);
        endcase
    endfunction

endpackage

// File: rtl/addsub_operand_sel.sv
module addsub_operand_sel
    import addsub_pkg::*;
(
    input  op_e               op_i,
    input  size_e             size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cf_i,
    output logic [DATA_W-1:0] x_o,
    output logic [DATA_W-1:0] y_o,
    output logic              c_o,
    output logic              sub_o,
    output logic              keep_cf_o,
    output logic              wr_o
);

    logic [DATA_W-1:0] msk;
    logic [DATA_W-1:0] am;
    logic [DATA_W-1:0] bm;

    always_comb begin
        msk       = size_mask(size_i);
        am        = a_i & msk;
        bm        = b_i & msk;
        x_o       = am;
        y_o       = bm;
        c_o       = 1'b0;
        sub_o     = 1'b0;
        keep_cf_o = 1'b0;
        wr_o      = (op_i != OP_CMP);
        case (op_i)
            OP_ADD: begin
                c_o = 1'b0;
            end
            OP_ADC: begin
                c_o = cf_i;
            end
            OP_SUB, OP_CMP: begin
                y_o   = ~bm & msk;
                c_o   = 1'b1;
                sub_o = 1'b1;
            end
            OP_SBB: begin
                y_o   = ~bm & msk;
                c_o   = ~cf_i;
                sub_o = 1'b1;
            end
            OP_INC: begin
                y_o       = '0;
                c_o       = 1'b1;
                keep_cf_o = 1'b1;
            end
            OP_DEC: begin
                y_o       = msk;
                c_o       = 1'b0;
                sub_o     = 1'b1;
                keep_cf_o = 1'b1;
            end
            default: begin
                x_o   = '0;
                y_o   = ~am & msk;
                c_o   = 1'b1;
                sub_o = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/addsub_adder.sv
module addsub_adder
    import addsub_pkg::*;
(
    input  logic [DATA_W-1:0] x_i,
    input  logic [DATA_W-1:0] y_i,
    input  logic              c_i,
    input  size_e             size_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              c4_o,
    output logic              ovf_o
);

    logic [DATA_W:0]    ext;
    logic [IDX_W-1:0]   top;

    always_comb begin
        ext    = {1'b0, x_i} + {1'b0, y_i} + {{DATA_W{1'b0}}, c_i};
        top    = top_bit(size_i);
        sum_o  = ext[DATA_W-1:0] & size_mask(size_i);
        cout_o = ext[top + IDX_W'(1)];
        c4_o   = x_i[4] ^ y_i[4] ^ ext[4];
        ovf_o  = (x_i[top] == y_i[top]) && (sum_o[top] != x_i[top]);
    end

endmodule

// File: rtl/addsub_flag_gen.sv
module addsub_flag_gen
    import addsub_pkg::*;
(
    input  logic [DATA_W-1:0] sum_i,
    input  size_e             size_i,
    input  logic              sub_i,
    input  logic              cout_i,
    input  logic              c4_i,
    input  logic              ovf_i,
    input  logic              keep_cf_i,
    input  logic              cf_q_i,
    output flags_t            flags_o
);

    always_comb begin
        flags_o.carry = keep_cf_i ? cf_q_i : (sub_i ? ~cout_i : cout_i);
        flags_o.aux   = sub_i ? ~c4_i : c4_i;
        flags_o.zero  = (sum_i == '0);
        flags_o.sign  = sum_i[top_bit(size_i)];
        flags_o.par   = ~^sum_i[7:0];
        flags_o.ovf   = ovf_i;
    end

endmodule

// File: rtl/addsub_flag_unit.sv
module addsub_flag_unit
    import addsub_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        op_i,
    input  logic [1:0]        size_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] result_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic              done_o
);

    unit_state_t       st_d, st_q;
    op_e               op;
    size_e             sz;
    logic [DATA_W-1:0] x, y, sum;
    logic              cin, is_sub, keep_cf, wr;
    logic              cout, c4, ovf;
    flags_t            fl;

    assign op = op_e'(op_i);
    assign sz = size_e'(size_i);

    addsub_operand_sel u_sel (
        .op_i      (op),
        .size_i    (sz),
        .a_i       (a_i),
        .b_i       (b_i),
        .cf_i      (st_q.flags.carry),
        .x_o       (x),
        .y_o       (y),
        .c_o       (cin),
        .sub_o     (is_sub),
        .keep_cf_o (keep_cf),
        .wr_o      (wr)
    );

    addsub_adder u_add (
        .x_i    (x),
        .y_i    (y),
        .c_i    (cin),
        .size_i (sz),
        .sum_o  (sum),
        .cout_o (cout),
        .c4_o   (c4),
        .ovf_o  (ovf)
    );

    addsub_flag_gen u_flg (
        .sum_i     (sum),
        .size_i    (sz),
        .sub_i     (is_sub),
        .cout_i    (cout),
        .c4_i      (c4),
        .ovf_i     (ovf),
        .keep_cf_i (keep_cf),
        .cf_q_i    (st_q.flags.carry),
        .flags_o   (fl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = start_i;
        if (start_i) begin
            st_d.flags = fl;
            if (wr) begin
                st_d.result = sum;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign result_o = st_q.result;
    assign flags_o  = st_q.flags;
    assign done_o   = st_q.done;

endmodule

// File: rtl/addsub_flag_unit_chk.sv
module addsub_flag_unit_chk
    import addsub_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [2:0]        op_i,
    input logic [1:0]        size_i,
    input logic [DATA_W-1:0] result_o,
    input logic [FLAG_W-1:0] flags_o,
    input logic              done_o
);

    assert_done_follows_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);

    assert_idle_holds_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> (!done_o && $stable(result_o) && $stable(flags_o)));

    assert_compare_keeps_result_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == OP_CMP) |=> $stable(result_o));

    assert_incdec_keep_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (op_i == OP_INC || op_i == OP_DEC)) |=> (flags_o[0] == $past(flags_o[0])));

    assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && size_i == SZ_BYTE && op_i != OP_CMP) |=> (result_o[DATA_W-1:8] == '0));

    assert_zero_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i != OP_CMP) |=> (flags_o[3] == (result_o == '0)));

    assert_parity_matches_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i != OP_CMP) |=> (flags_o[1] == ~^result_o[7:0]));

endmodule

bind addsub_flag_unit addsub_flag_unit_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .op_i     (op_i),
    .size_i   (size_i),
    .result_o (result_o),
    .flags_o  (flags_o),
    .done_o   (done_o)
);

// File: tb/tb_addsub_flag_unit.sv
`timescale 1ns/1ps
module tb_addsub_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic [1:0]  size_i = '0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [31:0] result_o;
    logic [5:0]  flags_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic        m_cf = 1'b0;
    logic [31:0] m_res = '0;

    always #4 clk = ~clk;

    addsub_flag_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .size_i(size_i),
        .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o), .done_o(done_o)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Issues one operation at the current negedge and checks it one edge later.
    task automatic do_op(input logic [2:0] op, input logic [1:0] sz,
                         input logic [31:0] a, input logic [31:0] b, input string req);
        longint n, msk, half, pa, qa, k, sp, sq, full, sr, res;
        logic ecf, eaf, eof, esub, keep;
        logic [31:0] eres;
        logic [5:0] efl;
        n    = (sz == 2'd0) ? 8 : (sz == 2'd1) ? 16 : 32;
        msk  = (longint'(1) << n) - 1;
        half = longint'(1) << (n - 1);
        pa = a & msk; qa = b & msk; k = 0; esub = 0; keep = 0;
        case (op)
            3'd1: k = m_cf;
            3'd2, 3'd6: esub = 1;
            3'd3: begin esub = 1; k = m_cf; end
            3'd4: begin qa = 1; keep = 1; end
            3'd5: begin qa = 1; keep = 1; esub = 1; end
            3'd7: begin qa = pa; pa = 0; esub = 1; end
            default: ;
        endcase
        sp = (pa >= half) ? pa - 2 * half : pa;
        sq = (qa >= half) ? qa - 2 * half : qa;
        if (esub) begin
            full = pa - qa - k; ecf = (pa < qa + k);
            eaf = ((pa & 15) < (qa & 15) + k); sr = sp - sq - k;
        end else begin
            full = pa + qa + k; ecf = (full > msk);
            eaf = (((pa & 15) + (qa & 15) + k) > 15); sr = sp + sq + k;
        end
        eof = (sr > half - 1) || (sr < -half);
        res = full & msk;
        if (keep) ecf = m_cf;
        efl = {eof, 1'(res >> (n - 1)), (res == 0), eaf,
               ($countones(res & 255) % 2 == 0), ecf};
        eres = (op == 3'd6) ? m_res : 32'(res);
        op_i = op; size_i = sz; a_i = a; b_i = b; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(req, "done", done_o, 1);
        chk(req, "result", result_o, eres);
        chk(req, "flags", flags_o, efl);
        m_cf = ecf; m_res = eres;
    endtask

    task automatic idle(input string req);
        @(negedge clk);
        chk(req, "done low when idle", done_o, 0);
        chk(req, "result held", result_o, m_res);
        chk(req, "carry held", flags_o[0], m_cf);
    endtask

    task automatic t_reset;
        chk("R1", "reset result", result_o, 0);
        chk("R1", "reset flags", flags_o, 0);
        chk("R1", "reset done", done_o, 0);
    endtask

    task automatic t_add_sizes;
        do_op(3'd0, 2'd0, 32'hFFFF_FF80, 32'h0000_0180, "R3 R2 byte carry, upper bits ignored");
        idle("R1");
        do_op(3'd0, 2'd1, 32'h7FFF, 32'h0001, "R9 word overflow");
        do_op(3'd0, 2'd2, 32'h0000_000F, 32'h0000_0001, "R10 aux carry");
        do_op(3'd0, 2'd3, 32'h8000_0000, 32'h8000_0000, "R8 R9 dword zero overflow");
    endtask

    task automatic t_carry_chain;
        do_op(3'd0, 2'd2, 32'hFFFF_FFFF, 32'h1, "R4 add sets carry");
        do_op(3'd1, 2'd2, 32'h0, 32'h0, "R4 adc back-to-back");
        do_op(3'd1, 2'd0, 32'h10, 32'h20, "R4 adc carry clear");
        do_op(3'd2, 2'd0, 32'h00, 32'h01, "R3 sub borrow");
        do_op(3'd3, 2'd0, 32'h05, 32'h02, "R4 sbb back-to-back");
        do_op(3'd3, 2'd1, 32'h8000, 32'h0001, "R9 sbb word overflow");
    endtask

    task automatic t_incdec;
        do_op(3'd2, 2'd0, 32'h0, 32'h1, "R5 set carry");
        do_op(3'd4, 2'd0, 32'hFF, 32'h0, "R5 inc wraps, carry kept 1");
        do_op(3'd4, 2'd1, 32'h7FFF, 32'h0, "R5 R9 inc overflow");
        do_op(3'd0, 2'd0, 32'h1, 32'h1, "R5 clear carry");
        do_op(3'd5, 2'd0, 32'h00, 32'h0, "R5 dec wraps, carry kept 0");
        do_op(3'd5, 2'd0, 32'h80, 32'h0, "R5 R9 dec overflow");
    endtask

    task automatic t_compare;
        do_op(3'd0, 2'd2, 32'h1234_5678, 32'h1, "R6 write before compare");
        do_op(3'd6, 2'd2, 32'h5, 32'h9, "R6 compare borrow keeps result");
        do_op(3'd6, 2'd0, 32'h42, 32'h42, "R6 compare equal sets zero");
        idle("R6");
    endtask

    task automatic t_negate;
        do_op(3'd7, 2'd0, 32'h0, 32'h0, "R7 neg zero no carry");
        do_op(3'd7, 2'd1, 32'h1, 32'h0, "R7 neg one");
        do_op(3'd7, 2'd0, 32'h80, 32'h0, "R7 R9 neg min overflow");
        do_op(3'd7, 2'd2, 32'h0000_0003, 32'hFFFF, "R7 R10 neg dword parity");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_add_sizes();
        t_carry_chain();
        t_incdec();
        t_compare();
        t_negate();
        idle("R1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule